// File: doc/BRIEF.md
# Machine-State Address Translation Unit

This block maps 16-bit processor logical addresses onto an 18-bit physical address space. That space is 256K words of nine bits, split into four banks of 64K. Translation works on 4K pages: the top four logical address bits pick one of sixteen entries, and each entry supplies a six-bit physical page number. Thirty-two complete entry sets sit in an internal map RAM.

Software does not choose the active set. On every cycle the block derives it from the machine state. An active DMA channel takes precedence. When no channel is active, the set comes from the bus-owning processor, its user or system state, and a small software-written base offset.

The block also handles the ninth bit of each memory word. It generates odd parity for write data and checks odd parity on read words. A check failure raises a sticky error flag, which a clear strobe resets. The same port that programs the map can read it back. DRAM timing and refresh are handled elsewhere.

Top module: `ms_xlate_unit`

## Requirements
- R1: One clock edge after the inputs are sampled, phys_addr[17:12] equals the page stored at entry log_addr[15:12] of the selected set, and phys_addr[11:0] equals log_addr[11:0].
- R2: When dma_active is 1, the selected set is 16 + dma_chan, whatever the values of cpu_id and user_mode.
- R3: When dma_active is 0, the selected set is ({cpu_id, user_mode, 3'b000} + base) modulo 32. The 3-bit base is loaded from base_val on a cycle with base_we high and takes effect from the next cycle.
- R4: A cycle with map_we high stores map_page at entry map_entry of set map_set. map_rd_page shows the stored page of (map_set, map_entry) one edge after sampling. On a same-cycle write to that location, the old value is shown (read-first).
- R5: bank_sel is one-hot, and its bit phys_addr[17:16] is the one set.
- R6: On a cycle with bus_wr high, par_out becomes ~^wr_data (odd parity over nine bits) one edge later. On other cycles par_out holds its value.
- R7: A cycle with bus_rd high and rd_word[8:0] holding an even number of ones sets par_err one edge later. par_err then stays set, and good reads do not clear it.
- R8: err_clr clears par_err one edge later, unless a failing read occurs in the same cycle, in which case par_err is set.
- R9: After synchronous reset, par_err = 0, par_out = 0 and base = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_id | input | 1 | Processor that owns the bus |
| user_mode | input | 1 | 1 = owning processor is in user state |
| dma_active | input | 1 | A DMA channel owns the cycle |
| dma_chan | input | 4 | Active DMA channel number |
| log_addr | input | 16 | Logical address |
| bus_rd | input | 1 | Read cycle strobe |
| bus_wr | input | 1 | Write cycle strobe |
| wr_data | input | 8 | Write data byte |
| rd_word | input | 9 | Word read from memory, parity in bit 8 |
| map_we | input | 1 | Map entry write strobe |
| map_set | input | 5 | Map set index for programming and readback |
| map_entry | input | 4 | Entry index within the set |
| map_page | input | 6 | Physical page to store |
| map_rd_page | output | 6 | Readback of the addressed entry |
| base_we | input | 1 | Load base offset |
| base_val | input | 3 | Base offset value |
| err_clr | input | 1 | Clear parity error flag |
| phys_addr | output | 18 | Physical address |
| bank_sel | output | 4 | One-hot bank select |
| par_out | output | 1 | Parity bit for the last write |
| par_err | output | 1 | Sticky parity error flag |

## Verification
If the set-selection logic is wrong, phys_addr carries a wrong page number on the very next cycle. Random map contents make almost any misrouted set or entry visible at once. A wrong base register or a wrong DMA priority shows only under the machine states that reach it, so directed cycles cover the highest set and DMA with both processor flags set. Parity faults show at par_out and par_err one edge after the strobe. A flag that is not sticky shows on the next good read, and a flag that does not clear shows on the cycle after err_clr.

// File: rtl/ms_xlate_pkg.sv
package ms_xlate_pkg;
  localparam int DEF_LOG_W  = 16;
  localparam int DEF_PHYS_W = 18;
  localparam int DEF_PAGE_W = 12;
  localparam int DEF_SET_W  = 5;
  localparam int DEF_BASE_W = 3;
  localparam int DEF_DATA_W = 8;
  localparam int DEF_BANK_W = 2;

  // odd parity bit: makes total ones count of {bit, data} odd
  function automatic logic odd_bit(input logic [63:0] v, input int w);
    logic acc;
    acc = 1'b1;
    for (int i = 0; i < w; i++) acc = acc ^ v[i];
    return acc;
  endfunction
endpackage

// File: rtl/ms_set_select.sv
module ms_set_select #(
  parameter int SET_W  = 5,
  parameter int BASE_W = 3,
  localparam int CH_W  = SET_W - 1
) (
  input  logic              cpu_id,
  input  logic              user_mode,
  input  logic              dma_active,
  input  logic [CH_W-1:0]   dma_chan,
  input  logic [BASE_W-1:0] base,
  output logic [SET_W-1:0]  set_idx
);
  logic [SET_W-1:0] state_set;
  logic [SET_W-1:0] base_ext;

  always_comb begin
    state_set = '0;
    state_set[SET_W-1] = cpu_id;
    state_set[SET_W-2] = user_mode;
    base_ext = SET_W'(base);
    if (dma_active) set_idx = {1'b1, dma_chan};
    else            set_idx = state_set + base_ext;
  end
endmodule

// File: rtl/ms_map_ram.sv
module ms_map_ram #(
  parameter int AW = 9,
  parameter int DW = 6,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic [AW-1:0] xl_addr,
  output logic [DW-1:0] xl_q,
  input  logic          pg_we,
  input  logic [AW-1:0] pg_addr,
  input  logic [DW-1:0] pg_wdata,
  output logic [DW-1:0] pg_q
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    xl_q <= mem[xl_addr];
  end

  always_ff @(posedge clk) begin
    pg_q <= mem[pg_addr];
    if (pg_we) mem[pg_addr] <= pg_wdata;
  end
endmodule

// File: rtl/ms_parity_unit.sv
module ms_parity_unit #(
  parameter int DATA_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_stb,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic            rd_stb,
  input  logic [DATA_W:0] rd_word,
  input  logic            clr,
  output logic            par_bit,
  output logic            err
);
  import ms_xlate_pkg::*;

  logic bad_rd;
  assign bad_rd = rd_stb && (^rd_word == 1'b0);

  always_ff @(posedge clk) begin
    if (rst) begin
      par_bit <= 1'b0;
      err     <= 1'b0;
    end else begin
      if (wr_stb) par_bit <= odd_bit(64'(wr_byte), DATA_W);
      if (bad_rd)   err <= 1'b1;
      else if (clr) err <= 1'b0;
    end
  end

  assert_par_gen_R6: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> (^{par_bit, $past(wr_byte)}) == 1'b1);
  assert_par_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |=> $stable(par_bit));
  assert_err_set_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !(^rd_word)) |=> err);
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (err && !clr) |=> err);
  assert_err_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (clr && !(rd_stb && !(^rd_word))) |=> !err);
endmodule

// File: rtl/ms_xlate_unit.sv
module ms_xlate_unit #(
  parameter int LOG_W  = ms_xlate_pkg::DEF_LOG_W,
  parameter int PHYS_W = ms_xlate_pkg::DEF_PHYS_W,
  parameter int PAGE_W = ms_xlate_pkg::DEF_PAGE_W,
  parameter int SET_W  = ms_xlate_pkg::DEF_SET_W,
  parameter int BASE_W = ms_xlate_pkg::DEF_BASE_W,
  parameter int DATA_W = ms_xlate_pkg::DEF_DATA_W,
  parameter int BANK_W = ms_xlate_pkg::DEF_BANK_W,
  localparam int IDX_W = LOG_W - PAGE_W,
  localparam int PPN_W = PHYS_W - PAGE_W,
  localparam int CH_W  = SET_W - 1,
  localparam int NBANK = 1 << BANK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_id,
  input  logic              user_mode,
  input  logic              dma_active,
  input  logic [CH_W-1:0]   dma_chan,
  input  logic [LOG_W-1:0]  log_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W:0]   rd_word,
  input  logic              map_we,
  input  logic [SET_W-1:0]  map_set,
  input  logic [IDX_W-1:0]  map_entry,
  input  logic [PPN_W-1:0]  map_page,
  output logic [PPN_W-1:0]  map_rd_page,
  input  logic              base_we,
  input  logic [BASE_W-1:0] base_val,
  input  logic              err_clr,
  output logic [PHYS_W-1:0] phys_addr,
  output logic [NBANK-1:0]  bank_sel,
  output logic              par_out,
  output logic              par_err
);
  localparam int AW = SET_W + IDX_W;

  logic [BASE_W-1:0] base_q;
  logic [SET_W-1:0]  set_idx;
  logic [PPN_W-1:0]  page_q;
  logic [PAGE_W-1:0] offs_q;

  always_ff @(posedge clk) begin
    if (rst)          base_q <= '0;
    else if (base_we) base_q <= base_val;
  end

  ms_set_select #(.SET_W(SET_W), .BASE_W(BASE_W)) u_sel (
    .cpu_id(cpu_id), .user_mode(user_mode), .dma_active(dma_active),
    .dma_chan(dma_chan), .base(base_q), .set_idx(set_idx)
  );

  ms_map_ram #(.AW(AW), .DW(PPN_W)) u_map (
    .clk(clk),
    .xl_addr({set_idx, log_addr[LOG_W-1 -: IDX_W]}),
    .xl_q(page_q),
    .pg_we(map_we),
    .pg_addr({map_set, map_entry}),
    .pg_wdata(map_page),
    .pg_q(map_rd_page)
  );

  always_ff @(posedge clk) begin
    offs_q <= log_addr[PAGE_W-1:0];
  end

  assign phys_addr = {page_q, offs_q};

  always_comb begin
    bank_sel = '0;
    bank_sel[page_q[PPN_W-1 -: BANK_W]] = 1'b1;
  end

  ms_parity_unit #(.DATA_W(DATA_W)) u_par (
    .clk(clk), .rst(rst), .wr_stb(bus_wr), .wr_byte(wr_data),
    .rd_stb(bus_rd), .rd_word(rd_word), .clr(err_clr),
    .par_bit(par_out), .err(par_err)
  );

  assert_offset_pass_R1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> phys_addr[PAGE_W-1:0] == $past(log_addr[PAGE_W-1:0]));
  assert_bank_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot(bank_sel) && bank_sel[phys_addr[PHYS_W-1 -: BANK_W]]);
  assert_base_load_R3: assert property (@(posedge clk) disable iff (rst)
    base_we |=> base_q == $past(base_val));
endmodule

// File: tb/tb_ms_xlate_unit.sv
module tb_ms_xlate_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_id = 0, user_mode = 0, dma_active = 0;
  logic [3:0] dma_chan = 0;
  logic [15:0] log_addr = 0;
  logic bus_rd = 0, bus_wr = 0;
  logic [7:0] wr_data = 0;
  logic [8:0] rd_word = 0;
  logic map_we = 0;
  logic [4:0] map_set = 0;
  logic [3:0] map_entry = 0;
  logic [5:0] map_page = 0;
  logic [5:0] map_rd_page;
  logic base_we = 0;
  logic [2:0] base_val = 0;
  logic err_clr = 0;
  logic [17:0] phys_addr;
  logic [3:0] bank_sel;
  logic par_out, par_err;

  int n_run = 0, n_fail = 0;
  logic [5:0] shadow [32][16];
  logic [2:0] base_m = 0;

  always #4 clk = ~clk;

  ms_xlate_unit dut (
    .clk(clk), .rst(rst), .cpu_id(cpu_id), .user_mode(user_mode),
    .dma_active(dma_active), .dma_chan(dma_chan), .log_addr(log_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .wr_data(wr_data), .rd_word(rd_word),
    .map_we(map_we), .map_set(map_set), .map_entry(map_entry),
    .map_page(map_page), .map_rd_page(map_rd_page), .base_we(base_we),
    .base_val(base_val), .err_clr(err_clr), .phys_addr(phys_addr),
    .bank_sel(bank_sel), .par_out(par_out), .par_err(par_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_set(input logic c, input logic u,
                                         input logic d, input logic [3:0] ch,
                                         input logic [2:0] b);
    if (d) return {1'b1, ch};
    return {c, u, 3'b000} + {2'b00, b};
  endfunction

  function automatic logic exp_par(input logic [7:0] d);
    return ~^d;
  endfunction

  task automatic xlate(input string req, input logic c, input logic u,
                       input logic d, input logic [3:0] ch, input logic [15:0] a);
    logic [4:0] s;
    logic [17:0] e;
    cpu_id = c; user_mode = u; dma_active = d; dma_chan = ch; log_addr = a;
    @(negedge clk);
    s = exp_set(c, u, d, ch, base_m);
    e = {shadow[s][a[15:12]], a[11:0]};
    check(req, 32'(phys_addr), 32'(e));
    check("R5", 32'(bank_sel), 32'(4'b0001 << e[17:16]));
  endtask

  task automatic set_base(input logic [2:0] b);
    base_we = 1; base_val = b;
    @(negedge clk);
    base_we = 0; base_m = b;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R9 reset state
    check("R9 par_err", 32'(par_err), 0);
    check("R9 par_out", 32'(par_out), 0);

    // R4 program whole map
    for (int s = 0; s < 32; s++) begin
      for (int e = 0; e < 16; e++) begin
        map_we = 1; map_set = 5'(s); map_entry = 4'(e);
        map_page = 6'($urandom);
        shadow[s][e] = map_page;
        @(negedge clk);
      end
    end
    map_we = 0;
    for (int i = 0; i < 24; i++) begin
      map_set = 5'($urandom); map_entry = 4'($urandom);
      @(negedge clk);
      check("R4 readback", 32'(map_rd_page), 32'(shadow[map_set][map_entry]));
    end
    // R4 read-first on same-cycle write
    map_set = 5'd9; map_entry = 4'd3;
    map_we = 1; map_page = ~shadow[9][3];
    @(negedge clk);
    map_we = 0;
    check("R4 read-first", 32'(map_rd_page), 32'(shadow[9][3]));
    shadow[9][3] = map_page;
    @(negedge clk);
    check("R4 new value", 32'(map_rd_page), 32'(shadow[9][3]));

    // R1/R2/R3 random translation with base 0 (reset value)
    for (int i = 0; i < 150; i++) begin
      logic d;
      d = 1'($urandom);
      xlate(d ? "R2 dma" : "R1 R3 state", 1'($urandom), 1'($urandom), d,
            4'($urandom), 16'($urandom));
    end
    set_base(3'd5);
    for (int i = 0; i < 100; i++) begin
      logic d;
      d = 1'($urandom);
      xlate(d ? "R2 dma" : "R3 base5", 1'($urandom), 1'($urandom), d,
            4'($urandom), 16'($urandom));
    end
    set_base(3'd7);
    xlate("R3 top set 31", 1, 1, 0, 4'd0, 16'hF123);
    xlate("R3 set 7", 0, 0, 0, 4'd0, 16'h0FFF);
    xlate("R2 over cpu1 user1", 1, 1, 1, 4'd0, 16'h7ABC);
    xlate("R2 chan 15", 0, 0, 1, 4'd15, 16'hFFFF);

    // R6 parity generation and hold
    for (int i = 0; i < 40; i++) begin
      bus_wr = 1; wr_data = 8'($urandom);
      @(negedge clk);
      check("R6 gen", 32'(par_out), 32'(exp_par(wr_data)));
    end
    bus_wr = 0; wr_data = 8'h01;
    begin
      logic keep;
      keep = par_out;
      @(negedge clk);
      check("R6 hold", 32'(par_out), 32'(keep));
    end

    // R7 good reads leave flag clear
    for (int i = 0; i < 20; i++) begin
      bus_rd = 1; wr_data = 8'($urandom);
      rd_word = {exp_par(wr_data), wr_data};
      @(negedge clk);
      check("R7 good read", 32'(par_err), 0);
    end
    // R7 bad read sets, sticky
    rd_word = {~exp_par(8'hA5), 8'hA5};
    @(negedge clk);
    check("R7 bad read", 32'(par_err), 1);
    rd_word = {exp_par(8'h3C), 8'h3C};
    @(negedge clk);
    check("R7 sticky", 32'(par_err), 1);
    bus_rd = 0;
    // R8 clear
    err_clr = 1;
    @(negedge clk);
    err_clr = 0;
    check("R8 clear", 32'(par_err), 0);
    // R8 set wins over clear
    err_clr = 1; bus_rd = 1; rd_word = 9'h000;
    @(negedge clk);
    err_clr = 0; bus_rd = 0;
    check("R8 set wins", 32'(par_err), 1);

    // R9 reset again restores base 0
    rst = 1;
    @(negedge clk);
    rst = 0; base_m = 0;
    check("R9 par_err after reset", 32'(par_err), 0);
    xlate("R9 base cleared", 1, 0, 0, 4'd0, 16'h5555);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule